// File: doc/BRIEF.md
# Mirrored 2K-Byte RAM Bank with Partial Address Decode

This block is a 2048-byte read/write memory bank that sits on the bus of an 8-bit processor with a 16-bit address. The address must already be latched and held steady. Each byte is held in two 4-bit-wide storage lanes that share one row index. The low lane keeps data bits 3:0 and the high lane keeps data bits 7:4. Both lanes answer to a single select line.

The select is built from the four most significant address bits only. The bank is chosen when all four of those bits are 1. Address bits 10:0 pick the row. Address bit 11 feeds neither the select nor the row index, so the bank appears twice in the address map: once at 0xF000–0xF7FF and again at 0xF800–0xFFFF. Every address below 0xF000 leaves the bank idle.

Reads and writes use two active-low strobes, one for read and one for write:

- **Write:** takes effect on the rising clock edge while the bank is selected and the write strobe is low.
- **Read:** the stored byte appears on the output in the same cycle, without a register, and a drive-enable flag rises.
- **Idle:** when the bank is not driving, the read output is held at 0x00, in place of a released (tri-stated) bus.

Top module: `mirrored_ram_bank`

## Requirements
- R1: The bank is selected only when address bits 15:12 are all 1. For every address from 0x0000 to 0xEFFF, `driveEn` stays 0 and a write strobe stores nothing.
- R2: When the bank is selected and `wrStrobeN` is 0 at a rising clock edge, `wrData` is stored at row `addr[10:0]`.
- R3: When the bank is selected, `rdStrobeN` is 0 and `wrStrobeN` is 1, `driveEn` is 1 and `rdData` shows the byte stored at row `addr[10:0]` in the same cycle.
- R4: Address bit 11 is ignored. A write at address A and a write at A ^ 0x0800 reach the same byte, so data written in 0xF800–0xFFFF reads back in 0xF000–0xF7FF and the reverse.
- R5: Bits 3:0 of a byte are kept in the low lane and bits 7:4 in the high lane. Bytes whose two nibbles differ (0x5A, 0xA5, 0x0F, 0xF0) read back unchanged.
- R6: When the bank is deselected, or when neither strobe is low, `driveEn` is 0 and `rdData` is 0x00.
- R7: When both strobes are low in one cycle, the write still happens, and `driveEn` stays 0 with `rdData` at 0x00.
- R8: While `rstN` is 0, no write is performed and `driveEn` is 0. Storage contents are not defined by reset.
- R9: The 2048 rows are distinct. Bytes written at 0xF000, 0xF400 and 0xF7FF read back independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rstN | input | 1 | Active-low reset; blocks writes and output drive |
| addr | input | 16 | Latched processor address |
| wrData | input | 8 | Byte to be written |
| rdStrobeN | input | 1 | Active-low memory read strobe |
| wrStrobeN | input | 1 | Active-low memory write strobe |
| rdData | output | 8 | Byte read, 0x00 when not driving |
| driveEn | output | 1 | 1 while the bank drives read data |

## Verification
A write counts once the rising edge after its strobe has been applied has passed. The bench drives the bus on a falling edge, so the write lands on the next rising edge, and the bench reads the location back from the following falling edge onward. Read data and `driveEn` are combinational, so they are due in the same cycle as the address and strobe. The bench samples them 2 ns after driving, while still inside that low clock phase, and no register lies on that path.

// File: rtl/rambank_pkg.sv
package rambank_pkg;
  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic arrayWrite;    // store wrData at the current row this edge
    logic outputEnable;  // put the stored byte on rdData
  } bankStrobes_t;
endpackage

// File: rtl/nibble_store.sv
module nibble_store #(
  parameter int INDEX_W = 11,
  parameter int WIDTH   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               writeEn,
  input  logic [INDEX_W-1:0] rowIdx,
  input  logic [WIDTH-1:0]   writeNib,
  output logic [WIDTH-1:0]   readNib
);
  localparam int DEPTH = 1 << INDEX_W;

  logic [WIDTH-1:0] cells [DEPTH];

  // No reset on storage: contents are undefined until written.
  always_ff @(posedge clk) begin
    if (writeEn) cells[rowIdx] <= writeNib;
  end

  assign readNib = cells[rowIdx];

  // R2: a write enabled on one edge is visible at that row after the edge.
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    writeEn |=> (cells[$past(rowIdx)] == $past(writeNib)));
endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import rambank_pkg::*;
#(
  parameter int              ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] DECODE_MASK  = 16'hF000,
  parameter logic [ADDR_W-1:0] DECODE_MATCH = 16'hF000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdStrobeN,
  input  logic              wrStrobeN,
  output bankStrobes_t      strobes
);
  logic bankSelN;

  // Partial decode: only the masked bits take part; the select is active low.
  assign bankSelN = !((addr & DECODE_MASK) == DECODE_MATCH);

  always_comb begin
    strobes.arrayWrite   = rstN && !bankSelN && !wrStrobeN;
    // Writes win over reads: never drive while writing.
    strobes.outputEnable = rstN && !bankSelN && !rdStrobeN && wrStrobeN;
  end

  // R8: nothing acts while reset is held.
  always_comb begin
    if (!rstN) a_r8_reset_quiet: assert (!strobes.arrayWrite && !strobes.outputEnable);
  end

  // R7: a low write strobe never lets the output drive.
  a_r7_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobeN |-> !strobes.outputEnable);

  // R1: any activity needs the top four address bits all set.
  a_r1_top_bits: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.outputEnable || strobes.arrayWrite) |-> (&addr[ADDR_W-1:ADDR_W-4]));
endmodule

// File: rtl/bank_datapath.sv
module bank_datapath
  import rambank_pkg::*;
#(
  parameter int INDEX_W  = 11,
  parameter int NIBBLE_W = 4,
  parameter int LANES    = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bankStrobes_t              strobes,
  input  logic [INDEX_W-1:0]        rowIdx,
  input  logic [LANES*NIBBLE_W-1:0] wrData,
  output logic [LANES*NIBBLE_W-1:0] rdData,
  output logic                      driveEn
);
  localparam int DATA_W = LANES * NIBBLE_W;

  logic [DATA_W-1:0] rawWord;

  // Lane 0 holds the low nibble, higher lanes hold the higher nibbles.
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    nibble_store #(.INDEX_W(INDEX_W), .WIDTH(NIBBLE_W)) u_store (
      .clk      (clk),
      .rstN     (rstN),
      .writeEn  (strobes.arrayWrite),
      .rowIdx   (rowIdx),
      .writeNib (wrData[lane*NIBBLE_W +: NIBBLE_W]),
      .readNib  (rawWord[lane*NIBBLE_W +: NIBBLE_W])
    );
  end

  assign driveEn = strobes.outputEnable;
  assign rdData  = strobes.outputEnable ? rawWord : '0;

  // R6: an idle bank shows a zero byte.
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !driveEn |-> (rdData == '0));
endmodule

// File: rtl/mirrored_ram_bank.sv
module mirrored_ram_bank
  import rambank_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int INDEX_W  = 11,
  parameter int NIBBLE_W = 4,
  parameter int LANES    = 2,
  parameter logic [ADDR_W-1:0] DECODE_MASK  = 16'hF000,
  parameter logic [ADDR_W-1:0] DECODE_MATCH = 16'hF000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*NIBBLE_W-1:0] wrData,
  input  logic                      rdStrobeN,
  input  logic                      wrStrobeN,
  output logic [LANES*NIBBLE_W-1:0] rdData,
  output logic                      driveEn
);
  bankStrobes_t strobes;

  bank_ctrl #(
    .ADDR_W(ADDR_W), .DECODE_MASK(DECODE_MASK), .DECODE_MATCH(DECODE_MATCH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr),
    .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN), .strobes(strobes)
  );

  bank_datapath #(
    .INDEX_W(INDEX_W), .NIBBLE_W(NIBBLE_W), .LANES(LANES)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rowIdx(addr[INDEX_W-1:0]), .wrData(wrData),
    .rdData(rdData), .driveEn(driveEn)
  );
endmodule

// File: tb/mirrored_ram_bank_tb.sv
module mirrored_ram_bank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wrData = 8'h00;
  logic        rdStrobeN = 1'b1;
  logic        wrStrobeN = 1'b1;
  logic [7:0]  rdData;
  logic        driveEn;

  int checkCount = 0;
  int failCount = 0;

  mirrored_ram_bank u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN),
    .rdData(rdData), .driveEn(driveEn)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, actual, expected);
    end
  endtask

  task automatic writeByte(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrStrobeN = 1'b0; rdStrobeN = 1'b1;
    @(negedge clk);
    wrStrobeN = 1'b1;
  endtask

  task automatic readExpect(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; rdStrobeN = 1'b0; wrStrobeN = 1'b1;
    #2;
    check(driveEn === 1'b1, {tag, " driveEn"}, int'(driveEn), 1);
    check(rdData === exp, {tag, " data"}, int'(rdData), int'(exp));
    rdStrobeN = 1'b1;
  endtask

  task automatic testReset();  // R8
    @(negedge clk);
    addr = 16'hF000; rdStrobeN = 1'b0;
    #2;
    check(driveEn === 1'b0, "R8 driveEn in reset", int'(driveEn), 0);
    check(rdData === 8'h00, "R8 rdData in reset", int'(rdData), 0);
    rdStrobeN = 1'b1;
    @(negedge clk); rstN = 1'b1;
    writeByte(16'hF020, 8'h11);
    @(negedge clk); rstN = 1'b0;
    writeByte(16'hF020, 8'hEE);
    @(negedge clk); rstN = 1'b1;
    readExpect(16'hF020, 8'h11, "R8 write blocked in reset");
  endtask

  task automatic testNibbles();  // R2 R3 R5
    writeByte(16'hF100, 8'h5A);
    writeByte(16'hF101, 8'hA5);
    writeByte(16'hF102, 8'h0F);
    writeByte(16'hF103, 8'hF0);
    readExpect(16'hF100, 8'h5A, "R5 0x5A");
    readExpect(16'hF101, 8'hA5, "R5 0xA5");
    readExpect(16'hF102, 8'h0F, "R2 0x0F");
    readExpect(16'hF103, 8'hF0, "R3 0xF0");
    writeByte(16'hF100, 8'h3C);
    readExpect(16'hF100, 8'h3C, "R2 overwrite");
  endtask

  task automatic testAlias();  // R4
    writeByte(16'hF923, 8'h96);
    readExpect(16'hF123, 8'h96, "R4 high alias to low");
    writeByte(16'hF7FE, 8'h69);
    readExpect(16'hFFFE, 8'h69, "R4 low alias to high");
    writeByte(16'hFFFF, 8'hC3);
    readExpect(16'hF7FF, 8'hC3, "R4 top byte alias");
  endtask

  task automatic testRows();  // R9
    writeByte(16'hF000, 8'h01);
    writeByte(16'hF400, 8'h04);
    writeByte(16'hF7FF, 8'h02);
    readExpect(16'hF000, 8'h01, "R9 row 0x000");
    readExpect(16'hF400, 8'h04, "R9 row 0x400");
    readExpect(16'hF7FF, 8'h02, "R9 row 0x7FF");
  endtask

  task automatic testDecode();  // R1
    writeByte(16'hF123, 8'h44);
    writeByte(16'h7123, 8'hEE);
    writeByte(16'hE923, 8'hEE);
    readExpect(16'hF123, 8'h44, "R1 low-address write ignored");
    for (int a = 0; a < 16'hF000; a += 16'h0100) begin
      @(negedge clk);
      addr = 16'(a) | 16'h00FF; rdStrobeN = 1'b0;
      #2;
      check(driveEn === 1'b0, "R1 no drive below 0xF000", int'(driveEn), 0);
      rdStrobeN = 1'b1;
    end
    @(negedge clk);
    addr = 16'hEFFF; rdStrobeN = 1'b0;
    #2;
    check(driveEn === 1'b0, "R1 0xEFFF", int'(driveEn), 0);
    rdStrobeN = 1'b1;
  endtask

  task automatic testIdle();  // R6
    writeByte(16'hF200, 8'h77);
    @(negedge clk);
    addr = 16'hF200; rdStrobeN = 1'b1; wrStrobeN = 1'b1;
    #2;
    check(driveEn === 1'b0, "R6 no strobe driveEn", int'(driveEn), 0);
    check(rdData === 8'h00, "R6 no strobe rdData", int'(rdData), 0);
    @(negedge clk);
    addr = 16'h3200; rdStrobeN = 1'b0;
    #2;
    check(rdData === 8'h00, "R6 deselected rdData", int'(rdData), 0);
    rdStrobeN = 1'b1;
  endtask

  task automatic testBothStrobes();  // R7
    writeByte(16'hF050, 8'h12);
    @(negedge clk);
    addr = 16'hF050; wrData = 8'hB7; rdStrobeN = 1'b0; wrStrobeN = 1'b0;
    #2;
    check(driveEn === 1'b0, "R7 driveEn both strobes", int'(driveEn), 0);
    check(rdData === 8'h00, "R7 rdData both strobes", int'(rdData), 0);
    @(negedge clk);
    rdStrobeN = 1'b1; wrStrobeN = 1'b1;
    readExpect(16'hF050, 8'hB7, "R7 write took effect");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testNibbles();
    testAlias();
    testRows();
    testDecode();
    testIdle();
    testBothStrobes();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checkCount++;
    failCount++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule